// File: doc/BRIEF.md
# Strobe-Driven Programmable Clock Divider

This block divides one of several parent tick streams by a programmable ratio and produces both a one-cycle output tick and a toggled clock-like signal with roughly even duty. Everything runs on a single system clock. Each parent source is a one-cycle enable strobe, so the block never switches real clocks and never crosses a clock domain.

A single 32-bit control word, written and read through a simple synchronous port, holds the ratio, a stop bit and a source-select field. The `NUM_SRC` parameter sets how many parents exist. The position of the select field depends on that count. A one-parent build has no select field.

A new ratio or source written while the divider runs is held back until the current output period finishes, so no period is ever cut short. Setting the stop bit silences the outputs at once and clears the phase. The first tick after a restart therefore comes a full period later.

Top module: `strobe_clock_divider`

## Requirements
- R1: The divide field sits in control bits [5:0]; the ratio is field+1 (1..64), and `div_tick_o` is high for exactly one cycle, one cycle after every ratio-th selected parent strobe.
- R2: With the divide field at 0, every selected parent strobe produces an output tick.
- R3: Control bit 8 is the stop bit. While it is 1, no ticks appear and `div_clk_o` is held at 0. After it is cleared, the first tick follows the ratio-th selected strobe, counted from the restart.
- R4: The read port returns the stored control word: divide field, stop bit (1 means gated, so enabled equals its inverse) and select field. Every other bit reads 0.
- R5: A write that keeps the stop bit at 1 while the stored stop bit is already 1 leaves the stored divide field unchanged.
- R6: Any write that leaves the stop bit at 1 with a resulting divide field of 0 stores 63 (ratio 64) instead.
- R7: The select field is bits [7:6] for two to four parents and bits [14:12] for five to eight parents. Its value N picks `src_tick_i[N]`.
- R8: With one parent there is no select field: those bits read 0, writes to them are ignored, and `src_tick_i[0]` is always used.
- R9: A select value at or above `NUM_SRC` produces no output ticks, and the written value still reads back.
- R10: A ratio or select change written while running takes effect only after the current output period completes.
- R11: After reset the control word reads 0x00000100: divide field 0, stop set, select 0.
- R12: `div_clk_o` inverts at every output tick and is 0 whenever the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_tick_i | input | NUM_SRC | One-cycle enable strobes, one per parent source |
| reg_we_i | input | 1 | Write enable for the control word |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Stored control word |
| div_tick_o | output | 1 | One-cycle divided output tick |
| div_clk_o | output | 1 | Toggled output, inverting at each tick |

## Verification
The assertions assume that the parent strobes are plain synchronous levels, sampled once per system clock, and that a write is a single-cycle pulse on `reg_we_i` with stable data. They do not assume any spacing between strobes, so back-to-back strobes at ratio 1 are legal. The bench drives every input on the falling edge and holds each for exactly one cycle. It stops the divider before it moves away from an out-of-range select, because a running divider only takes a new configuration at a period boundary, and with an out-of-range select that boundary never comes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_W    = 6;
    localparam int SEL_W    = 3;
    localparam int STOP_POS = 8;
    localparam int REG_W    = 32;

    typedef struct packed {
        logic             stop;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{stop: 1'b1, sel: '0, div: '0};

    // Low bit of the select field for a given parent count.
    function automatic int sel_lsb(input int n);
        return (n <= 4) ? 6 : 12;
    endfunction

    // Bits of the select field that exist for a given parent count.
    function automatic logic [SEL_W-1:0] sel_mask(input int n);
        if (n <= 1)      return 3'b000;
        else if (n <= 4) return 3'b011;
        else             return 3'b111;
    endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output cfg_t             cfg_q_o,
    output cfg_t             cfg_nxt_o,
    output logic [REG_W-1:0] rdata_o
);

    localparam int               LSB  = sel_lsb(NUM_SRC);
    localparam logic [SEL_W-1:0] MASK = sel_mask(NUM_SRC);

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.stop = wdata_i[STOP_POS];
            cfg_d.sel  = wdata_i[LSB +: SEL_W] & MASK;
            // Staying stopped keeps the stored ratio.
            if (!(cfg_q.stop && wdata_i[STOP_POS]))
                cfg_d.div = wdata_i[DIV_W-1:0];
            // A stopped divider never holds a zero divide field.
            if (cfg_d.stop && (cfg_d.div == '0))
                cfg_d.div = '1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= CFG_RESET;
        else         cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o                  = '0;
        rdata_o[DIV_W-1:0]       = cfg_q.div;
        rdata_o[STOP_POS]        = cfg_q.stop;
        rdata_o[LSB +: SEL_W]    = rdata_o[LSB +: SEL_W] | cfg_q.sel;
    end

    assign cfg_q_o   = cfg_q;
    assign cfg_nxt_o = cfg_d;

    assert_keep_div_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && cfg_q.stop && wdata_i[STOP_POS] && (cfg_q.div != '0)) |=> $stable(cfg_q.div));

    assert_no_zero_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wdata_i[STOP_POS]) |=> (cfg_q.div != '0));

endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               strobe_o
);

    always_comb begin
        strobe_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) strobe_o = src_i[i];
        end
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_i,
    input  logic [DIV_W-1:0] nxt_div_i,
    input  logic [SEL_W-1:0] nxt_sel_i,
    input  logic             strobe_i,
    output logic [SEL_W-1:0] act_sel_o,
    output logic             tick_o,
    output logic             tgl_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             tick;
        logic             tgl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (stop_i) begin
            st_d.cnt = '0;
            st_d.tgl = 1'b0;
            st_d.div = nxt_div_i;
            st_d.sel = nxt_sel_i;
        end else if (strobe_i) begin
            if (st_q.cnt == st_q.div) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
                st_d.tgl  = ~st_q.tgl;
                st_d.div  = nxt_div_i;
                st_d.sel  = nxt_sel_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign act_sel_o = st_q.sel;
    assign tick_o    = st_q.tick;
    assign tgl_o     = st_q.tgl;

    assert_quiet_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!tick_o && !tgl_o));

    assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.div);

    assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_i && !strobe_i) |=> ($stable(st_q.div) && $stable(st_q.sel)));

    assert_tgl_follows_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_i && !strobe_i) |=> $stable(tgl_o));

endmodule

// File: rtl/strobe_clock_divider.sv
module strobe_clock_divider
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic               reg_we_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               div_tick_o,
    output logic               div_clk_o
);

    cfg_t             cfg_q, cfg_nxt;
    logic [SEL_W-1:0] act_sel;
    logic             strobe;
    logic             unused_cfg;
    assign unused_cfg = ^{cfg_q.sel, cfg_q.div};

    clkdiv_ctrl_reg #(.NUM_SRC(NUM_SRC)) u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .wdata_i   (reg_wdata_i),
        .cfg_q_o   (cfg_q),
        .cfg_nxt_o (cfg_nxt),
        .rdata_o   (reg_rdata_o)
    );

    clkdiv_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
        .src_i    (src_tick_i),
        .sel_i    (act_sel),
        .strobe_o (strobe)
    );

    clkdiv_counter u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stop_i    (cfg_q.stop),
        .nxt_div_i (cfg_nxt.div),
        .nxt_sel_i (cfg_nxt.sel),
        .strobe_i  (strobe),
        .act_sel_o (act_sel),
        .tick_o    (div_tick_o),
        .tgl_o     (div_clk_o)
    );

    assert_stop_reads_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[STOP_POS] |=> !div_tick_o);

endmodule

// File: tb/sim_strobe_clock_divider.sv
module sim_strobe_clock_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1, rd2;
    logic        tk0, tk1, tk2, ck0, ck1, ck2;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    strobe_clock_divider #(.NUM_SRC(8)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rd0), .div_tick_o(tk0), .div_clk_o(ck0));
    strobe_clock_divider #(.NUM_SRC(3)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src[2:0]), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rd1), .div_tick_o(tk1), .div_clk_o(ck1));
    strobe_clock_divider #(.NUM_SRC(1)) u2 (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src[0:0]), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rd2), .div_tick_o(tk2), .div_clk_o(ck2));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk); src = m;
        @(negedge clk); src = '0;
    endtask

    task automatic t_reset;
        chk("R11 u0 reset word", rd0, 32'h100);
        chk("R11 u1 reset word", rd1, 32'h100);
        chk("R11 u2 reset word", rd2, 32'h100);
        chk("R3 no tick at reset", {31'd0, tk0}, 0);
        chk("R12 clk low at reset", {31'd0, ck0}, 0);
    endtask

    task automatic t_ratio;
        wr(32'h003);
        chk("R4 readback ratio 4", rd0, 32'h003);
        for (int i = 1; i <= 8; i++) begin
            pulse(8'h01);
            chk("R1 tick on 4th strobe", {31'd0, tk0}, (i % 4 == 0) ? 1 : 0);
            if (i == 4) chk("R12 clk high after 1st tick", {31'd0, ck0}, 1);
            if (i == 8) chk("R12 clk low after 2nd tick", {31'd0, ck0}, 0);
        end
    endtask

    task automatic t_ratio1;
        wr(32'h100);
        chk("R6 stop with zero field", rd0, 32'h13F);
        wr(32'h000);
        for (int i = 1; i <= 3; i++) begin
            pulse(8'h01);
            chk("R2 every strobe ticks", {31'd0, tk0}, 1);
            chk("R12 clk alternates", {31'd0, ck0}, i % 2);
        end
    endtask

    task automatic t_stop;
        wr(32'h100);
        chk("R6 stop forces 63", rd0, 32'h13F);
        pulse(8'h01);
        chk("R3 no tick when stopped", {31'd0, tk0}, 0);
        chk("R3 clk held low", {31'd0, ck0}, 0);
    endtask

    task automatic t_hold;
        wr(32'h105);
        chk("R5 stopped field kept", rd0, 32'h13F);
        wr(32'h002);
        chk("R4 running word", rd0, 32'h002);
        for (int i = 1; i <= 3; i++) begin
            pulse(8'h01);
            chk("R3 clean phase after restart", {31'd0, tk0}, (i == 3) ? 1 : 0);
        end
        chk("R12 clk after restart tick", {31'd0, ck0}, 1);
    endtask

    task automatic t_change;
        pulse(8'h01);
        chk("R10 mid period no tick", {31'd0, tk0}, 0);
        wr(32'h000);
        chk("R4 new word visible", rd0, 32'h000);
        pulse(8'h01);
        chk("R10 old ratio still counting", {31'd0, tk0}, 0);
        pulse(8'h01);
        chk("R10 old period completes", {31'd0, tk0}, 1);
        pulse(8'h01);
        chk("R10 new ratio in force", {31'd0, tk0}, 1);
    endtask

    task automatic t_select;
        wr(32'h100);
        wr(32'h5000);
        chk("R7 u0 select readback", rd0, 32'h5000);
        chk("R4 u1 upper bits read zero", rd1, 32'h0);
        chk("R8 u2 no select field", rd2, 32'h0);
        pulse(8'h01);
        chk("R7 unselected source ignored", {31'd0, tk0}, 0);
        chk("R7 u1 uses source 0", {31'd0, tk1}, 1);
        pulse(8'h20);
        chk("R7 source 5 selected", {31'd0, tk0}, 1);
    endtask

    task automatic t_range;
        wr(32'h100);
        wr(32'h0C0);
        chk("R9 u1 reads out-of-range select", rd1, 32'h0C0);
        chk("R4 u0 bits 7:6 read zero", rd0, 32'h000);
        chk("R8 u2 ignores select write", rd2, 32'h000);
        pulse(8'h07);
        chk("R9 no tick out of range", {31'd0, tk1}, 0);
        chk("R8 u2 always source 0", {31'd0, tk2}, 1);
        wr(32'h100);
        wr(32'h040);
        chk("R7 u1 select at bits 7:6", rd1, 32'h040);
        pulse(8'h02);
        chk("R7 u1 source 1 selected", {31'd0, tk1}, 1);
        chk("R8 u2 ignores source 1", {31'd0, tk2}, 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ratio;
        t_ratio1;
        t_stop;
        t_hold;
        t_change;
        t_select;
        t_range;
        done = 1'b1;
        summary;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary;
            $finish;
        end
    end

endmodule